// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch is taken, and learns from each branch once it resolves in execute. It keeps a table of two-bit entries. Each entry holds a direction guess and a flag that records whether the last guess made from that entry was wrong. A guess changes only after two wrong outcomes in a row, so a single odd outcome, such as a loop exit, does not flip the entry.

The table is split into sets. A short shift register of recent resolved outcomes picks the set, and the fetch PC bits just above the byte offset pick the entry inside that set. Branches whose outcomes follow one another therefore train separate entries. The lookup port is purely combinational: a PC goes in and the guess comes out in the same cycle. The update port takes a resolved PC, its actual outcome and a valid strobe. The table write and the history shift both take effect at the next clock edge.

The reset input is asserted asynchronously. Its release passes through two flops inside the block, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `bdir_predictor`

## Requirements
- R1: While reset is applied and after it is released, every entry reads as state 2'b00 (guess not-taken, last guess right) and the history register is zero.
- R2: `lk_state[1]` is the direction guess (1 = taken) and `lk_state[0]` is 1 when the last guess made from that entry was wrong. `lk_taken` always equals `lk_state[1]`.
- R3: A wrong outcome on an entry whose wrong flag is 0 keeps its guess and sets the wrong flag.
- R4: An outcome equal to the guess clears the wrong flag and keeps the guess.
- R5: A wrong outcome on an entry whose wrong flag is 1 inverts the guess and clears the wrong flag.
- R6: The entry inside a set is chosen by PC bits [7:2] (IDX_W = 6, OFS_W = 2). PCs that differ only in bits [1:0] or in bits above 7 share an entry.
- R7: Each valid update shifts its outcome into history bit 0, and the old bit 0 moves to bit 1. The set number is the history value, giving 4 sets. An update uses the history as it stands before its own shift, and a lookup uses the current history.
- R8: When `upd_valid` is 0, the values on `upd_pc` and `upd_taken` change neither the table nor the history.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup returns the state before the update.
- R10: The lookup outputs follow `lk_pc` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_state | output | 2 | Selected entry: {guess, last-wrong} |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
A single branch PC is trained with repeated outcomes that are broken up by not-taken updates on an unrelated PC. These updates bring the history back to the same set, so the four transitions (first miss, second miss, hit after a miss, hit while right) can each be seen on one entry. Lookups at the same PC under different histories show that the sets are kept apart. Lookups at PCs that differ only in the byte offset or in the bits above the index show which PCs alias. Cycles with `upd_valid` low but busy update data show that the update fields are ignored. A lookup made in the same cycle as an update to that entry shows that the lookup returns the state before the update.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef struct packed {
    logic pred_tkn;   // direction guess, 1 = taken
    logic miss_last;  // 1 = last guess from this entry was wrong
  } bdp_ent_t;

  localparam bdp_ent_t BDP_RESET = '{pred_tkn: 1'b0, miss_last: 1'b0};

  // Two wrong outcomes in a row are needed to invert the guess.
  function automatic bdp_ent_t bdp_next(input bdp_ent_t cur, input logic taken);
    bdp_ent_t nxt;
    if (cur.pred_tkn == taken) begin
      nxt = '{pred_tkn: cur.pred_tkn, miss_last: 1'b0};
    end else if (!cur.miss_last) begin
      nxt = '{pred_tkn: cur.pred_tkn, miss_last: 1'b1};
    end else begin
      nxt = '{pred_tkn: ~cur.pred_tkn, miss_last: 1'b0};
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bdp_rst_sync.sv
module bdp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/bdp_history.sv
module bdp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W:0]   cat;
  logic [HIST_W-1:0] hist_d;
  logic [HIST_W-1:0] hist_q;

  // Newest outcome enters bit 0; the oldest bit drops off the top.
  always_comb begin
    cat    = {hist_q, bit_in};
    hist_d = cat[HIST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/bdp_index.sv
module bdp_index #(
  parameter int IDX_W = 6,
  parameter int SET_W = 2,
  localparam int HW   = (SET_W > 0) ? SET_W : 1,
  localparam int TI_W = IDX_W + SET_W
) (
  input  logic [IDX_W-1:0] pc_bits,
  input  logic [HW-1:0]    hist,
  output logic [TI_W-1:0]  idx
);

  generate
    if (SET_W > 0) begin : g_banked
      assign idx = {hist, pc_bits};
    end else begin : g_flat
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx = pc_bits;
    end
  endgenerate

endmodule

// File: rtl/bdp_table.sv
module bdp_table
  import bdp_pkg::*;
#(
  parameter int  TI_W = 8,
  localparam int N    = 1 << TI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TI_W-1:0] rd_idx,
  output bdp_ent_t        rd_ent,
  input  logic            wr_en,
  input  logic [TI_W-1:0] wr_idx,
  input  logic            wr_taken,
  output bdp_ent_t        wr_cur,
  output logic [2*N-1:0]  ent_flat
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_ent
      bdp_ent_t ent_q;
      bdp_ent_t ent_d;
      logic     ent_en;

      always_comb begin
        ent_en = wr_en && (wr_idx == TI_W'(i));
        ent_d  = bdp_next(ent_q, wr_taken);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q <= BDP_RESET;
        end else if (ent_en) begin
          ent_q <= ent_d;
        end
      end

      assign ent_flat[2*i +: 2] = ent_q;
    end
  endgenerate

  // Reads see the registered array, so a same-cycle write is not visible.
  assign rd_ent = bdp_ent_t'(ent_flat[{rd_idx, 1'b0} +: 2]);
  assign wr_cur = bdp_ent_t'(ent_flat[{wr_idx, 1'b0} +: 2]);

endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor
  import bdp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFS_W = 2,
  parameter int IDX_W = 6,
  parameter int SET_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [1:0]      lk_state,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int HW   = (SET_W > 0) ? SET_W : 1;
  localparam int TI_W = IDX_W + SET_W;
  localparam int N    = 1 << TI_W;

  logic            rst_q;
  logic [HW-1:0]   ghist;
  logic [TI_W-1:0] lk_idx;
  logic [TI_W-1:0] upd_idx;
  bdp_ent_t        lk_ent;
  bdp_ent_t        upd_cur;
  logic [2*N-1:0]  ent_flat;

  bdp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  generate
    if (SET_W > 0) begin : g_hist
      bdp_history #(.HIST_W(SET_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_q),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist_o   (ghist)
      );
    end else begin : g_nohist
      assign ghist = '0;
    end
  endgenerate

  bdp_index #(.IDX_W(IDX_W), .SET_W(SET_W)) u_lk_idx (
    .pc_bits (lk_pc[OFS_W +: IDX_W]),
    .hist    (ghist),
    .idx     (lk_idx)
  );

  bdp_index #(.IDX_W(IDX_W), .SET_W(SET_W)) u_upd_idx (
    .pc_bits (upd_pc[OFS_W +: IDX_W]),
    .hist    (ghist),
    .idx     (upd_idx)
  );

  bdp_table #(.TI_W(TI_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_q),
    .rd_idx   (lk_idx),
    .rd_ent   (lk_ent),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken),
    .wr_cur   (upd_cur),
    .ent_flat (ent_flat)
  );

  assign lk_taken = lk_ent.pred_tkn;
  assign lk_state = {lk_ent.pred_tkn, lk_ent.miss_last};

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
  parameter int  TI_W  = 8,
  parameter int  HW    = 2,
  parameter int  SET_W = 2,
  localparam int N     = 1 << TI_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic [TI_W-1:0] upd_idx,
  input logic [1:0]      upd_cur,
  input logic [2*N-1:0]  ent_flat,
  input logic [HW-1:0]   ghist
);

  function automatic logic [1:0] ent_at(input logic [2*N-1:0] f, input logic [TI_W-1:0] i);
    return f[{i, 1'b0} +: 2];
  endfunction

  // R3: first wrong outcome keeps the guess and raises the flag
  a_r3_first_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_cur[0] && (upd_cur[1] != upd_taken))
    |=> ent_at(ent_flat, $past(upd_idx)) == {$past(upd_cur[1]), 1'b1});

  // R4: matching outcome clears the flag and keeps the guess
  a_r4_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_cur[1] == upd_taken))
    |=> ent_at(ent_flat, $past(upd_idx)) == {$past(upd_cur[1]), 1'b0});

  // R5: second wrong outcome in a row inverts the guess
  a_r5_second_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_cur[0] && (upd_cur[1] != upd_taken))
    |=> ent_at(ent_flat, $past(upd_idx)) == {~$past(upd_cur[1]), 1'b0});

  // R8: no valid update leaves table and history untouched
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(ent_flat) && $stable(ghist)));

  generate
    if (SET_W > 0) begin : g_hist_chk
      // R7: the resolved outcome lands in history bit 0
      a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist[0] == $past(upd_taken)));
    end
  endgenerate

endmodule

bind bdir_predictor bdp_checker #(.TI_W(TI_W), .HW(HW), .SET_W(SET_W)) u_bdp_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .upd_idx   (upd_idx),
  .upd_cur   (upd_cur),
  .ent_flat  (ent_flat),
  .ghist     (ghist)
);

// File: tb/bdir_predictor_test.sv
module bdir_predictor_test;

  localparam int IW = 6;
  localparam int SW = 2;
  localparam int NE = 1 << (IW + SW);

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic [1:0]  lk_state;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;

  int n_chk;
  int n_bad;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  logic [1:0]    m_tab [NE];
  logic [SW-1:0] m_hist;

  bdir_predictor uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .lk_state  (lk_state),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [IW+SW-1:0] m_idx(input logic [31:0] pc, input logic [SW-1:0] h);
    return {h, pc[7:2]};
  endfunction

  // Expected state rules of R3, R4, R5
  function automatic logic [1:0] m_next(input logic [1:0] s, input logic t);
    if (s[1] == t) return {s[1], 1'b0};
    if (!s[0])     return {s[1], 1'b1};
    return {~s[1], 1'b0};
  endfunction

  task automatic step(input logic [31:0] lpc, input logic uv, input logic [31:0] upc,
                      input logic ut, input string tag);
    logic [IW+SW-1:0] ui;
    @(negedge clk);
    lk_pc     = lpc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_taken = ut;
    #1;
    exp_q.push_back(m_tab[m_idx(lpc, m_hist)]);
    tag_q.push_back(tag);
    if (uv) begin
      ui = m_idx(upc, m_hist);
      m_tab[ui] = m_next(m_tab[ui], ut);
      m_hist = {m_hist[0], ut};
    end
  endtask

  task automatic look(input logic [31:0] pc, input string tag);
    step(pc, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic upd(input logic [31:0] pc, input logic t, input string tag);
    step(pc, 1'b1, pc, t, tag);
  endtask

  // Two not-taken updates elsewhere bring the history back to set 0
  task automatic flush();
    upd(32'h3C, 1'b0, "R7 flush");
    upd(32'h3C, 1'b0, "R7 flush");
  endtask

  // Scoreboard monitor: compares well after the inputs settle, before the next edge
  initial begin
    logic [1:0] e;
    string      t;
    forever begin
      @(negedge clk);
      #8;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (lk_state !== e) begin
          n_bad++;
          $display("FAIL %s lk_state actual=%b expected=%b", t, lk_state, e);
        end
        n_chk++;
        if (lk_taken !== e[1]) begin
          n_bad++;
          $display("FAIL R2 (%s) lk_taken actual=%b expected=%b", t, lk_taken, e[1]);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    for (int i = 0; i < NE; i++) m_tab[i] = 2'b00;
    m_hist    = '0;
    rst_n     = 1'b0;
    lk_pc     = 32'h0;
    upd_valid = 1'b0;
    upd_pc    = 32'h0;
    upd_taken = 1'b0;
    repeat (4) @(negedge clk);
    // R1: state during reset
    n_chk++;
    if (lk_state !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 in reset lk_state actual=%b expected=00", lk_state);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    look(32'h0000_0000, "R1");
    look(32'h0000_0020, "R1");
    look(32'h0000_00FC, "R1");
    look(32'hFFFF_FF3C, "R1");

    upd(32'h20, 1'b1, "R3 train");
    look(32'h20, "R7 other set");
    flush();
    look(32'h20, "R3");
    upd(32'h20, 1'b1, "R5 train");
    flush();
    look(32'h20, "R5");
    upd(32'h20, 1'b1, "R4 train");
    flush();
    look(32'h20, "R4");
    upd(32'h20, 1'b0, "R3 train taken");
    flush();
    look(32'h20, "R3 from taken");
    upd(32'h20, 1'b1, "R4 train");
    flush();
    look(32'h20, "R4 clears flag");

    look(32'h21, "R6 offset");
    look(32'h23, "R6 offset");
    look(32'h120, "R6 high alias");
    look(32'hABCD_0020, "R6 high alias");
    look(32'h24, "R6 neighbour");

    step(32'h20, 1'b0, 32'h20, 1'b0, "R8");
    step(32'h20, 1'b0, 32'h20, 1'b1, "R8");
    step(32'h24, 1'b0, 32'h24, 1'b0, "R8");
    look(32'h20, "R8 after idle");

    step(32'h20, 1'b1, 32'h20, 1'b0, "R9 same cycle");
    look(32'h44, "R10");
    flush();
    look(32'h20, "R9 next");

    upd(32'h44, 1'b1, "R7 train");
    upd(32'h44, 1'b1, "R7 train");
    look(32'h44, "R7 set3");
    upd(32'h3C, 1'b0, "R7");
    look(32'h44, "R7 set2");
    upd(32'h3C, 1'b0, "R7");
    look(32'h44, "R7 set0");
    look(32'h20, "R10");

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule